// File: doc/BRIEF.md
# Stereo Serial Output Port

This block takes a pair of signed audio words, left and right, and sends them out on one serial data line that goes with a bit clock and a frame clock. Every frame has two halves of 32 bit slots each. The left word goes in the first half and the right word in the second. Each word is sent most significant bit first and is right-justified, so its last bit fills the final slot of its half and the unused leading slots are low. Software or an upstream filter presents a new pair on the parallel inputs with a one-cycle load strobe. The pair goes out in the next frame that starts after the load.

The block has two clocking modes. As clock master it divides its system clock, which runs at 256 times the frame rate, to make a 64x bit clock, a 2x word clock and a 50%-duty frame clock. As slave it takes the bit and frame clocks from outside, passes each through a synchronizer into the system clock domain, and acts on their edges. Mode inputs set the word length (16 or 20 bits), the frame-clock level that marks the left half, the bit-clock edge on which data changes, and a mute that forces the data line low.

Top module: `stereo_out_port`

## Requirements
- R1: In master mode (slaveMode=0) the bit clock toggles every 2 system clocks, so there are 128 transitions per frame. Each frame-clock half lasts 128 system clocks. The word clock toggles every 64 system clocks, so there are 4 toggles per frame. The frame clock changes only on the same cycle as a bit-clock transition.
- R2: In slave mode (slaveMode=1) the bits are timed from the external bckIn and lrckIn, and bckOut, wdckOut and lrckOut are held at 0.
- R3: With shortWord=1 a half carries the 16 bits leftIn[19:4] (or rightIn[19:4]). With shortWord=0 it carries all 20 bits of the input word.
- R4: Each half is exactly 32 bit slots. The word is sent MSB first and ends in the last slot of the half. All earlier slots are 0.
- R5: A pair loaded with loadStrobe goes out in the next frame that begins after the load, left word in the first half and right word in the second.
- R6: With lrPolHigh=1 the left half has frame clock 0 and the right half has frame clock 1. With lrPolHigh=0 the levels are swapped. This holds in both modes.
- R7: With bckPolHigh=1 dout changes just after a rising bit-clock edge and is sampled on the falling edge. With bckPolHigh=0 it changes after a falling edge and is sampled on the rising edge.
- R8: While muteN=0, dout is 0.
- R9: While rst_n=0 (with lrPolHigh=1), dout is 0, lrckOut is 0 (left level) and wdckOut is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 256 times the frame rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| leftIn | input | 20 | Left word, two's complement |
| rightIn | input | 20 | Right word, two's complement |
| loadStrobe | input | 1 | Captures leftIn and rightIn as a pair |
| slaveMode | input | 1 | 1: clocks come from outside; 0: block makes them |
| shortWord | input | 1 | 1: 16-bit words; 0: 20-bit words |
| lrPolHigh | input | 1 | 1: left half is frame clock low |
| bckPolHigh | input | 1 | 1: data changes on rising bit-clock edge |
| muteN | input | 1 | 0 forces dout low |
| bckIn | input | 1 | External bit clock (slave mode) |
| lrckIn | input | 1 | External frame clock (slave mode) |
| bckOut | output | 1 | Bit clock (master mode) |
| wdckOut | output | 1 | Word clock at twice the frame rate (master mode) |
| lrckOut | output | 1 | Frame clock (master mode) |
| dout | output | 1 | Serial data |

## Verification
The bench decodes the serial line the way a receiver would. It latches bits on the edge opposite the change edge and splits halves on the frame clock. A shifter that was off by one slot would show up as a shifted word or a half that is not 32 slots long. Dropping the zero padding would show up as stray high bits ahead of the MSB. Word values with all bits set, alternating bits and set sign bits expose an error in choosing 16 or 20 bits, and a left/right swap or a stale right word shows up because the two words of each pair differ. Each polarity setting is run in both master and slave timing. In the slave runs the synchronizer delay puts the data change several cycles after the clock edge, and a design that acted on the wrong edge would corrupt the bits the bench latches.

// File: rtl/sop_pkg.sv
package sop_pkg;
  // Strobes from the control to the datapath, one set per system clock
  typedef struct packed {
    logic shift;      // advance to the next slot of the current half
    logic loadLeft;   // first slot of a left half
    logic loadRight;  // first slot of a right half
  } sopStrobe_t;
endpackage

// File: rtl/sop_ctrl.sv
module sop_ctrl
  import sop_pkg::*;
#(
  parameter int SLOTS       = 32,
  parameter int DIV         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slaveMode,
  input  logic       lrPolHigh,
  input  logic       bckPolHigh,
  input  logic       bckIn,
  input  logic       lrckIn,
  output logic       bckOut,
  output logic       wdckOut,
  output logic       lrckOut,
  output sopStrobe_t strobe
);
  localparam int DIV_W = $clog2(DIV);
  localparam int CNT_W = $clog2(SLOTS * 2 * DIV);

  logic [CNT_W-1:0] divCnt;
  logic [SYNC_STAGES-1:0] bckSync, lrSync;
  logic bckPrev, lastLeft;
  logic bckM, lrM, wdM;
  logic bckLevel, lrLevel, chgEdge, isLeft, newHalf;

  // Divider chain for master mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) divCnt <= '0;
    else        divCnt <= divCnt + 1'b1;
  end

  // Slot boundary is the change edge of the selected polarity
  assign bckM = divCnt[DIV_W-1] ^ bckPolHigh;
  assign lrM  = divCnt[CNT_W-1] ^ ~lrPolHigh;
  assign wdM  = divCnt[CNT_W-2];

  // Synchronizers for external clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bckSync <= '0;
      lrSync  <= '0;
    end else begin
      bckSync <= {bckSync[SYNC_STAGES-2:0], bckIn};
      lrSync  <= {lrSync[SYNC_STAGES-2:0], lrckIn};
    end
  end

  assign bckLevel = slaveMode ? bckSync[SYNC_STAGES-1] : bckM;
  assign lrLevel  = slaveMode ? lrSync[SYNC_STAGES-1]  : lrM;

  assign chgEdge = bckPolHigh ? (bckLevel & ~bckPrev) : (~bckLevel & bckPrev);
  assign isLeft  = (lrLevel != lrPolHigh);
  assign newHalf = (isLeft != lastLeft);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bckPrev  <= 1'b0;
      lastLeft <= 1'b0;
    end else begin
      bckPrev <= bckLevel;
      if (chgEdge) lastLeft <= isLeft;
    end
  end

  assign strobe.shift     = chgEdge & ~newHalf;
  assign strobe.loadLeft  = chgEdge & newHalf & isLeft;
  assign strobe.loadRight = chgEdge & newHalf & ~isLeft;

  assign bckOut  = ~slaveMode & bckM;
  assign wdckOut = ~slaveMode & wdM;
  assign lrckOut = ~slaveMode & lrM;
endmodule

// File: rtl/sop_data.sv
module sop_data
  import sop_pkg::*;
#(
  parameter int WORD_W  = 20,
  parameter int SHORT_W = 16,
  parameter int SLOTS   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] leftIn,
  input  logic [WORD_W-1:0] rightIn,
  input  logic              loadStrobe,
  input  logic              shortWord,
  input  logic              muteN,
  input  sopStrobe_t        strobe,
  output logic              dout
);
  localparam int PAD_LONG  = SLOTS - WORD_W;
  localparam int PAD_SHORT = SLOTS - SHORT_W;

  logic [WORD_W-1:0] holdL, holdR, pendR;
  logic [SLOTS-1:0]  shifter, frameL, frameR;
  logic              doutReg;

  // Right-justified half image, leading slots zero
  function automatic logic [SLOTS-1:0] halfImage(input logic [WORD_W-1:0] w,
                                                  input logic isShort);
    if (isShort) return {{PAD_SHORT{1'b0}}, w[WORD_W-1 -: SHORT_W]};
    else         return {{PAD_LONG{1'b0}}, w};
  endfunction

  assign frameL = halfImage(holdL, shortWord);
  assign frameR = halfImage(pendR, shortWord);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdL   <= '0;
      holdR   <= '0;
      pendR   <= '0;
      shifter <= '0;
      doutReg <= 1'b0;
    end else begin
      if (loadStrobe) begin
        holdL <= leftIn;
        holdR <= rightIn;
      end
      if (strobe.loadLeft) begin
        doutReg <= frameL[SLOTS-1];
        shifter <= frameL << 1;
        pendR   <= holdR;
      end else if (strobe.loadRight) begin
        doutReg <= frameR[SLOTS-1];
        shifter <= frameR << 1;
      end else if (strobe.shift) begin
        doutReg <= shifter[SLOTS-1];
        shifter <= shifter << 1;
      end
    end
  end

  assign dout = doutReg & muteN;
endmodule

// File: rtl/stereo_out_port.sv
module stereo_out_port
  import sop_pkg::*;
#(
  parameter int WORD_W      = 20,
  parameter int SHORT_W     = 16,
  parameter int SLOTS       = 32,
  parameter int DIV         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] leftIn,
  input  logic [WORD_W-1:0] rightIn,
  input  logic              loadStrobe,
  input  logic              slaveMode,
  input  logic              shortWord,
  input  logic              lrPolHigh,
  input  logic              bckPolHigh,
  input  logic              muteN,
  input  logic              bckIn,
  input  logic              lrckIn,
  output logic              bckOut,
  output logic              wdckOut,
  output logic              lrckOut,
  output logic              dout
);
  sopStrobe_t strobe;

  sop_ctrl #(.SLOTS(SLOTS), .DIV(DIV), .SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .slaveMode(slaveMode), .lrPolHigh(lrPolHigh),
    .bckPolHigh(bckPolHigh), .bckIn(bckIn), .lrckIn(lrckIn),
    .bckOut(bckOut), .wdckOut(wdckOut), .lrckOut(lrckOut), .strobe(strobe)
  );

  sop_data #(.WORD_W(WORD_W), .SHORT_W(SHORT_W), .SLOTS(SLOTS)) data_i (
    .clk(clk), .rst_n(rst_n), .leftIn(leftIn), .rightIn(rightIn),
    .loadStrobe(loadStrobe), .shortWord(shortWord), .muteN(muteN),
    .strobe(strobe), .dout(dout)
  );
endmodule

// File: rtl/sop_checker.sv
module sop_checker (
  input logic clk,
  input logic rst_n,
  input logic slaveMode,
  input logic lrPolHigh,
  input logic bckPolHigh,
  input logic muteN,
  input logic bckOut,
  input logic wdckOut,
  input logic lrckOut,
  input logic dout
);
  AST_SLAVE_CLKS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    slaveMode |-> (bckOut == 1'b0 && wdckOut == 1'b0 && lrckOut == 1'b0)); // R2

  AST_MUTE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !muteN |-> dout == 1'b0); // R8

  AST_BCK_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    (!slaveMode && !$past(slaveMode) && $stable(bckPolHigh) && !$stable(bckOut))
      |=> (!slaveMode && $stable(bckPolHigh)) -> $stable(bckOut)); // R1

  AST_LRCK_ON_BCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!slaveMode && !$past(slaveMode) && $stable(lrPolHigh) && $stable(bckPolHigh)
      && !$stable(lrckOut)) |-> !$stable(bckOut)); // R1

  AST_DATA_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(dout) && muteN && $past(muteN) && !slaveMode && !$past(slaveMode)
      && !$past(slaveMode, 2) && $stable(bckPolHigh) && $past(bckPolHigh, 2) == bckPolHigh)
      |-> ($past(bckOut) == bckPolHigh && $past(bckOut, 2) != bckPolHigh)); // R7
endmodule

bind stereo_out_port sop_checker chk_i (
  .clk(clk), .rst_n(rst_n), .slaveMode(slaveMode), .lrPolHigh(lrPolHigh),
  .bckPolHigh(bckPolHigh), .muteN(muteN), .bckOut(bckOut), .wdckOut(wdckOut),
  .lrckOut(lrckOut), .dout(dout)
);

// File: tb/stereo_out_port_tb_top.sv
module stereo_out_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [19:0] leftIn = '0, rightIn = '0;
  logic loadStrobe = 1'b0, slaveMode = 1'b0, shortWord = 1'b0;
  logic lrPolHigh = 1'b1, bckPolHigh = 1'b1, muteN = 1'b1;
  logic bckIn = 1'b0, lrckIn = 1'b0;
  logic bckOut, wdckOut, lrckOut, dout;

  always #2 clk = ~clk;  // 250 MHz

  stereo_out_port dut_i (
    .clk(clk), .rst_n(rst_n), .leftIn(leftIn), .rightIn(rightIn),
    .loadStrobe(loadStrobe), .slaveMode(slaveMode), .shortWord(shortWord),
    .lrPolHigh(lrPolHigh), .bckPolHigh(bckPolHigh), .muteN(muteN),
    .bckIn(bckIn), .lrckIn(lrckIn), .bckOut(bckOut), .wdckOut(wdckOut),
    .lrckOut(lrckOut), .dout(dout)
  );

  typedef struct {
    logic [19:0] l, r;
    logic isShort, mute, slave;
    int tag;
    string req;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0, frameCount = 0;
  bit finished = 0;
  event frameEv;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expHalf(input logic [19:0] w, input logic s, input logic m);
    if (m) return 32'h0;
    return s ? {16'h0, w[19:4]} : {12'h0, w};
  endfunction

  // Slave clock source: each slot is 8 system clocks, change edge first
  initial begin
    forever begin
      for (int s = 0; s < 64; s++) begin
        @(posedge clk); #1;
        lrckIn = (s >= 32) ? lrPolHigh : ~lrPolHigh;
        bckIn  = bckPolHigh;
        repeat (4) @(posedge clk);
        #1 bckIn = ~bckPolHigh;
        repeat (3) @(posedge clk);
      end
    end
  end

  // Monitor: a receiver model of the serial line
  logic prevB = 1'b0, prevW = 1'b0, prevLeft = 1'b0;
  logic actB, actL, curLeft, capture;
  logic [31:0] acc = '0, gotL = '0, gotR = '0;
  int nBits = 0, nL = 0, nR = 0, halfClk = 0, clkL = 0;
  int bckEdges = 0, wdTog = 0, slaveBad = 0;

  task automatic frameDone();
    if (q.size() > 0 && q[0].tag == frameCount - 1) begin
      item_t it = q.pop_front();
      check(gotL == expHalf(it.l, it.isShort, it.mute), {it.req, " R4 R5 left word"}, "left", gotL, expHalf(it.l, it.isShort, it.mute));
      check(gotR == expHalf(it.r, it.isShort, it.mute), {it.req, " R4 R5 right word"}, "right", gotR, expHalf(it.r, it.isShort, it.mute));
      check(nL == 32 && nR == 32, "R4 slots per half", "slots", nL * 100 + nR, 3232);
      if (it.slave) begin
        check(slaveBad == 0, "R2 clock outputs low", "highSamples", slaveBad, 0);
      end else begin
        check(bckEdges == 128, "R1 bit clock transitions", "edges", bckEdges, 128);
        check(wdTog == 4, "R1 word clock toggles", "toggles", wdTog, 4);
        check(clkL == 128, "R1 half length", "clocks", clkL, 128);
      end
    end
    bckEdges = 0; wdTog = 0; slaveBad = 0;
    frameCount++;
    -> frameEv;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      actB = slaveMode ? bckIn : bckOut;
      actL = slaveMode ? lrckIn : lrckOut;
      halfClk++;
      if (actB != prevB) bckEdges++;
      if (wdckOut != prevW) wdTog++;
      if (slaveMode && (bckOut || wdckOut || lrckOut)) slaveBad++;
      capture = bckPolHigh ? (prevB && !actB) : (!prevB && actB);  // R7 sampling edge
      if (capture) begin
        curLeft = (actL != lrPolHigh);  // R6
        if (curLeft != prevLeft) begin
          if (prevLeft) begin gotL = acc; nL = nBits; clkL = halfClk; end
          else begin gotR = acc; nR = nBits; end
          acc = '0; nBits = 0; halfClk = 0;
          if (curLeft) frameDone();
        end
        acc = {acc[30:0], dout};
        nBits++;
        prevLeft = curLeft;
      end
      prevB = actB;
      prevW = wdckOut;
    end
  end

  // Driver: sets modes and a pair, then queues the expectation
  task automatic send(input logic [19:0] l, input logic [19:0] r, input logic s,
                      input logic m, input logic sl, input logic bp, input logic lp,
                      input string req);
    item_t it;
    @(frameEv);
    @(negedge clk);
    shortWord = s; muteN = ~m; slaveMode = sl; bckPolHigh = bp; lrPolHigh = lp;
    leftIn = l; rightIn = r; loadStrobe = 1'b1;
    @(negedge clk);
    loadStrobe = 1'b0;
    @(frameEv);
    it.l = l; it.r = r; it.isShort = s; it.mute = m; it.slave = sl;
    it.tag = frameCount; it.req = req;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (6) @(negedge clk);
    check(dout == 1'b0, "R9 reset dout", "dout", dout, 0);
    check(lrckOut == 1'b0, "R9 reset frame clock", "lrck", lrckOut, 0);
    check(wdckOut == 1'b0, "R9 reset word clock", "wdck", wdckOut, 0);
    rst_n = 1'b1;
    send(20'h9A5C3, 20'h1234F, 0, 0, 0, 1, 1, "R3 20-bit master");
    send(20'h8001F, 20'h7FFE1, 1, 0, 0, 1, 1, "R3 16-bit master");
    send(20'hA5A5A, 20'h5A5A5, 0, 0, 0, 1, 0, "R6 inverted frame polarity");
    send(20'hC3C3C, 20'h3C3C3, 0, 0, 0, 0, 1, "R7 falling change edge");
    send(20'hFFFFF, 20'hFFFFF, 0, 1, 0, 1, 1, "R8 mute");
    send(20'hFFFFF, 20'h00000, 0, 0, 0, 0, 0, "R4 full and empty words");
    send(20'h6D2B1, 20'hE4F07, 0, 0, 1, 1, 1, "R2 slave 20-bit");
    send(20'hF0F0F, 20'h0F0F0, 1, 0, 1, 0, 0, "R2 R6 R7 slave 16-bit");
    send(20'h80000, 20'h7FFFF, 0, 0, 1, 1, 0, "R2 R5 slave sign extremes");
    send(20'h13579, 20'hECA86, 1, 0, 0, 0, 0, "R3 R7 master 16-bit");
    finish_run();
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      finish_run();
    end
  end
endmodule